// File: doc/BRIEF.md
# Two-Dimensional Strided Burst Address Generator

This block walks a rectangular region of memory and issues a stream of burst requests for it. One start pulse gives it four values: a base address, the row length in bytes minus one, the number of rows minus one, and the row pitch. The row pitch is the distance from the first byte of one row to the first byte of the next. The pitch may be larger than the row length, which leaves a gap between rows. When the row count is zero the walk is a plain linear transfer of a single row.

Each row is cut into requests. A request never carries more than a fixed maximum number of bytes, and it never runs across a 4 KiB address boundary. Every request is offered on a valid/ready handshake toward the memory side. The block also exposes the address it is currently working on, so that software or a monitor can watch progress. A one-cycle completion pulse marks the end of the last row.

Top module: `stride_walker`

## Requirements
- R1: After reset, `busy`, `req_valid` and `done` are all low.
- R2: When `start` is high while the block is idle, it captures the parameters. From the next cycle, `busy` and `req_valid` are high and the first request address equals `start_addr`.
- R3: Each request's byte count is the smallest of three values: the bytes left in the current row, `MAX_BURST`, and the bytes left before the next 4 KiB boundary (4096 minus the address modulo 4096). It is therefore never zero and never crosses a 4 KiB boundary.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_bytes` keep their values into the next cycle.
- R5: Row n (counting from 0) begins at `start_addr + n*row_pitch`. Within a row, each request begins where the previous one ended.
- R6: A walk produces exactly `row_len_m1+1` bytes in each of `row_cnt_m1+1` rows and no further requests. The total is the product of the two.
- R7: `done` is high for exactly one cycle: the cycle after the handshake of the final request of the final row. `busy` falls on the same edge.
- R8: A `start` pulse while `busy` is high is ignored, and the running walk continues unchanged.
- R9: `cur_addr` equals `req_addr` while busy. After completion it holds `start_addr + row_cnt_m1*row_pitch + row_len_m1 + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled only when idle |
| start_addr | input | ADDR_W | Base address of row 0 |
| row_len_m1 | input | LEN_W | Row length in bytes, minus one |
| row_cnt_m1 | input | ROWS_W | Number of rows, minus one |
| row_pitch | input | ADDR_W | Address step between row starts |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Request start address |
| req_bytes | output | $clog2(MAX_BURST)+1 | Request byte count |
| cur_addr | output | ADDR_W | Live current address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `MAX_BURST` = 64, `LEN_W` = 12 and `ROWS_W` = 8. A 64-byte cap lets rows of a few hundred bytes split into several requests, so the cap, the row-remainder case and a 4 KiB crossing can all appear within short runs. The pitch is 32 bits wide, which allows non-aligned gaps between rows. A single-byte, single-row walk covers the smallest legal lengths.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sw_state_e;

    localparam int SW_PAGE_W     = 12;
    localparam int SW_PAGE_BYTES = 1 << SW_PAGE_W;

    function automatic logic [31:0] sw_min(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sw_burst_calc.sv
module sw_burst_calc #(
    parameter int ADDR_W    = 32,
    parameter int REM_W     = 17,
    parameter int MAX_BURST = 256,
    parameter int BW        = $clog2(MAX_BURST) + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REM_W-1:0]  row_rem,
    output logic [BW-1:0]     bytes
);
    import sw_pkg::*;

    logic [31:0] to_page;
    logic [31:0] rem32;
    logic [31:0] capped;

    always_comb begin
        to_page = 32'(SW_PAGE_BYTES) - 32'(addr[SW_PAGE_W-1:0]);
        rem32   = 32'(row_rem);
    end

    generate
        if (MAX_BURST >= SW_PAGE_BYTES) begin : g_page_only
            always_comb capped = sw_min(rem32, to_page);
        end else begin : g_cap_and_page
            always_comb capped = sw_min(sw_min(rem32, 32'(MAX_BURST)), to_page);
        end
    endgenerate

    assign bytes = capped[BW-1:0];

endmodule

// File: rtl/sw_row_track.sv
module sw_row_track #(
    parameter int ADDR_W = 32,
    parameter int ROWS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] pitch_in,
    input  logic [ROWS_W-1:0] rows_m1_in,
    output logic [ADDR_W-1:0] next_base,
    output logic              last_row
);
    logic [ADDR_W-1:0] row_base_q;
    logic [ADDR_W-1:0] pitch_q;
    logic [ROWS_W-1:0] rows_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_base_q  <= '0;
            pitch_q     <= '0;
            rows_left_q <= '0;
        end else if (load) begin
            row_base_q  <= base_in;
            pitch_q     <= pitch_in;
            rows_left_q <= rows_m1_in;
        end else if (advance) begin
            row_base_q  <= row_base_q + pitch_q;
            rows_left_q <= rows_left_q - 1'b1;
        end
    end

    assign next_base = row_base_q + pitch_q;
    assign last_row  = (rows_left_q == '0);

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl #(
    parameter int ADDR_W = 32,
    parameter int REM_W  = 17,
    parameter int BW     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [REM_W-1:0]  row_len,
    input  logic [ADDR_W-1:0] next_base,
    input  logic              last_row,
    input  logic [BW-1:0]     bytes,
    input  logic              req_ready,
    output logic              load,
    output logic              advance,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [REM_W-1:0]  row_rem,
    output logic              done
);
    import sw_pkg::*;

    sw_state_e         state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [REM_W-1:0]  rem_q;
    logic [REM_W-1:0]  len_q;
    logic              done_q;
    logic              accept;
    logic              row_end;
    logic              finish;

    always_comb begin
        load    = (state_q == SW_IDLE) && start;
        accept  = (state_q == SW_RUN) && req_ready;
        row_end = accept && (32'(bytes) == 32'(rem_q));
        advance = row_end && !last_row;
        finish  = row_end && last_row;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            cur_q   <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                state_q <= SW_RUN;
                cur_q   <= start_addr;
                rem_q   <= row_len;
                len_q   <= row_len;
            end else if (accept) begin
                if (advance) begin
                    cur_q <= next_base;
                    rem_q <= len_q;
                end else if (finish) begin
                    state_q <= SW_IDLE;
                    cur_q   <= cur_q + ADDR_W'(bytes);
                    rem_q   <= '0;
                end else begin
                    cur_q <= cur_q + ADDR_W'(bytes);
                    rem_q <= rem_q - REM_W'(bytes);
                end
            end
        end
    end

    assign busy     = (state_q == SW_RUN);
    assign cur_addr = cur_q;
    assign row_rem  = rem_q;
    assign done     = done_q;

endmodule

// File: rtl/stride_walker.sv
module stride_walker #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int ROWS_W    = 12,
    parameter int MAX_BURST = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic [LEN_W-1:0]             row_len_m1,
    input  logic [ROWS_W-1:0]            row_cnt_m1,
    input  logic [ADDR_W-1:0]            row_pitch,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [ADDR_W-1:0]            req_addr,
    output logic [$clog2(MAX_BURST):0]   req_bytes,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic                         busy,
    output logic                         done
);
    localparam int REM_W = LEN_W + 1;
    localparam int BW    = $clog2(MAX_BURST) + 1;

    logic              load;
    logic              advance;
    logic [ADDR_W-1:0] next_base;
    logic              last_row;
    logic [REM_W-1:0]  row_len;
    logic [REM_W-1:0]  row_rem;
    logic [BW-1:0]     bytes;
    logic [ADDR_W-1:0] cur;
    logic              run;

    assign row_len = {1'b0, row_len_m1} + REM_W'(1);

    sw_row_track #(.ADDR_W(ADDR_W), .ROWS_W(ROWS_W)) u_rows (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .advance    (advance),
        .base_in    (start_addr),
        .pitch_in   (row_pitch),
        .rows_m1_in (row_cnt_m1),
        .next_base  (next_base),
        .last_row   (last_row)
    );

    sw_burst_calc #(.ADDR_W(ADDR_W), .REM_W(REM_W), .MAX_BURST(MAX_BURST), .BW(BW)) u_burst (
        .addr    (cur),
        .row_rem (row_rem),
        .bytes   (bytes)
    );

    sw_ctrl #(.ADDR_W(ADDR_W), .REM_W(REM_W), .BW(BW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .row_len    (row_len),
        .next_base  (next_base),
        .last_row   (last_row),
        .bytes      (bytes),
        .req_ready  (req_ready),
        .load       (load),
        .advance    (advance),
        .busy       (run),
        .cur_addr   (cur),
        .row_rem    (row_rem),
        .done       (done)
    );

    assign busy      = run;
    assign req_valid = run;
    assign req_addr  = cur;
    assign req_bytes = bytes;
    assign cur_addr  = cur;

endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BURST = 256
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [$clog2(MAX_BURST):0] req_bytes,
    input logic                       busy,
    input logic                       done
);
    a_r1_idle_no_request: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    a_r3_burst_bounds: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_bytes != '0) && (32'(req_bytes) <= 32'(MAX_BURST)));

    a_r3_no_page_cross: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (32'(req_addr[11:0]) + 32'(req_bytes)) <= 32'd4096);

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_bytes));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_after_handshake: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !req_ready) |=> busy && !done);

endmodule

bind stride_walker sw_checker #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_sw_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_stride_walker.sv
`timescale 1ns/1ps
module sim_stride_walker;
    localparam int AW   = 32;
    localparam int LW   = 12;
    localparam int RWD  = 8;
    localparam int MAXB = 64;
    localparam int BW   = $clog2(MAXB) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] row_len_m1 = '0;
    logic [RWD-1:0] row_cnt_m1 = '0;
    logic [AW-1:0] row_pitch = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [BW-1:0] req_bytes;
    logic [AW-1:0] cur_addr;
    logic          busy;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stride_walker #(.ADDR_W(AW), .LEN_W(LW), .ROWS_W(RWD), .MAX_BURST(MAXB)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .row_len_m1(row_len_m1), .row_cnt_m1(row_cnt_m1), .row_pitch(row_pitch),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .cur_addr(cur_addr), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One walk checked against a bench model. stall: 0 always ready, 1 ready every third cycle.
    task automatic run_walk(input string name, input longint sa, input int len_m1,
                            input int rows_m1, input longint pitch, input int stall,
                            input bit inject);
        longint len, row, off, addr, expb, total, page_left;
        bit exp_done_now, exp_done_next, finished, hold, rdy;
        longint held_a, held_b;
        int cyc;
        len = len_m1 + 1; row = 0; off = 0; total = 0;
        exp_done_now = 0; exp_done_next = 0; finished = 0; hold = 0; cyc = 0;
        held_a = 0; held_b = 0;
        @(negedge clk);
        start = 1'b1; start_addr = AW'(sa); row_len_m1 = LW'(len_m1);
        row_cnt_m1 = RWD'(rows_m1); row_pitch = AW'(pitch); req_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(busy && req_valid, "R2", {name, " busy after start"}, longint'(busy), 1);
        check(longint'(req_addr) == sa, "R2", {name, " first address"}, longint'(req_addr), sa);
        while (cyc < 5000) begin
            if (exp_done_now) begin
                check(done == 1'b1, "R7", {name, " done pulse"}, longint'(done), 1);
                check(busy == 1'b0, "R7", {name, " busy low at done"}, longint'(busy), 0);
                check(longint'(cur_addr) == ((sa + rows_m1 * pitch + len) & 64'hFFFF_FFFF), "R9",
                      {name, " final cur_addr"}, longint'(cur_addr),
                      (sa + rows_m1 * pitch + len) & 64'hFFFF_FFFF);
                check(total == len * (rows_m1 + 1), "R6", {name, " total bytes"}, total,
                      len * (rows_m1 + 1));
                req_ready = 1'b0;
                @(negedge clk);
                check(done == 1'b0, "R7", {name, " done one cycle"}, longint'(done), 0);
                return;
            end
            if (done) check(0, "R7", {name, " early done"}, 1, 0);
            if (finished && req_valid) check(0, "R6", {name, " extra request"}, 1, 0);
            if (hold) begin
                check(req_valid && longint'(req_addr) == held_a && longint'(req_bytes) == held_b,
                      "R4", {name, " stalled request held"}, longint'(req_addr), held_a);
            end
            if (req_valid)
                check(cur_addr == req_addr, "R9", {name, " cur_addr live"},
                      longint'(cur_addr), longint'(req_addr));
            rdy = (stall == 0) ? 1'b1 : ((cyc % 3) == 0);
            req_ready = rdy;
            if (inject && cyc == 1) begin
                start = 1'b1; start_addr = 32'hDEAD_0000; row_len_m1 = 3; row_cnt_m1 = 0;
                row_pitch = 4;
            end
            if (req_valid && rdy && !finished) begin
                addr = (sa + row * pitch + off) & 64'hFFFF_FFFF;
                page_left = 4096 - (addr % 4096);
                expb = len - off;
                if (expb > MAXB) expb = MAXB;
                if (expb > page_left) expb = page_left;
                check(longint'(req_addr) == addr, inject ? "R8" : "R5", {name, " request address"},
                      longint'(req_addr), addr);
                check(longint'(req_bytes) == expb, "R3", {name, " request bytes"},
                      longint'(req_bytes), expb);
                total += expb;
                off += expb;
                if (off == len) begin
                    off = 0; row++;
                    if (row > rows_m1) begin finished = 1; exp_done_next = 1; end
                end
            end
            hold = req_valid && !rdy;
            held_a = longint'(req_addr); held_b = longint'(req_bytes);
            @(negedge clk);
            start = 1'b0;
            cyc++;
            exp_done_now = exp_done_next;
            exp_done_next = 0;
        end
        check(0, "R7", {name, " walk did not finish"}, cyc, 0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R1", "reset state",
              longint'({busy, req_valid, done}), 0);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        // R6 linear row: 200 bytes from 0x1000 -> 64,64,64,8
        run_walk("linear", 64'h1000, 199, 0, 0, 0, 0);
        // R5 2D with gap between rows
        run_walk("strided", 64'h2000, 47, 3, 100, 0, 0);
        // R3 4 KiB crossing: 0x0FF0 with 64 bytes -> 16 then 48
        run_walk("page_cross", 64'h0FF0, 63, 0, 0, 0, 0);
        // R4 backpressure on a multi-row walk
        run_walk("stalled", 64'h3F80, 129, 2, 256, 1, 0);
        // R8 start pulse while busy is ignored
        run_walk("busy_start", 64'h5000, 255, 1, 512, 0, 1);
        // R6 smallest walk: one byte, one row
        run_walk("single_byte", 64'h7001, 0, 0, 0, 0, 0);
        // R5 rows crossing a page boundary
        run_walk("rows_over_page", 64'h8FC0, 99, 2, 128, 1, 0);
        summary();
        $finish;
    end

endmodule